// File: doc/BRIEF.md
# Identity ROM Header Validator

This block checks the header of a device identity image as the image streams in, one byte for each cycle in which `in_valid_i` is high. Byte 0 of the stream is taken as the first byte of the image. As bytes arrive, the block captures the header fields and runs two checksums in step with the stream. It stops when the image is complete, and it reports the result through one `done_o` pulse.

The header carries the following fields, all multi-byte ones least-significant byte first:

| Bytes | Content |
|-------|---------|
| 0 | identifier check byte |
| 1..8 | 64-bit identifier |
| 9..12 | stored data checksum |
| 13 | revision |
| 14..15 | length word; its low 10 bits are the data length |
| 16..17 | vendor code |
| 18..19 | model code |

The total image size is the data length plus 13. The data checksum covers the bytes from byte 13 up to the last byte of the image.

The source feeding the block may flag its final byte with `in_last_i`. If that flag arrives before the image is complete, the image is truncated and the result is fatal. The results are held until the next `done_o` pulse. The next valid byte after a `done_o` pulse starts a new image. Fetching bytes from storage and walking the entries that follow the header are left to neighbouring blocks.

Top module: `idrom_hdr_check`

## Requirements
- R1: `ident_o` equals bytes 1..8 taken little-endian. A CRC-8 is run over bytes 1..8. It starts at 0xFF, uses polynomial 0x07, shifts MSB first and applies no final inversion. If the result differs from byte 0, `fatal_o` is set.
- R2: `image_size_o` equals (byte14 | byte15<<8) & 0x3FF, plus 13. Bits 7..2 of byte 15 have no effect.
- R3: If the total size is below 22, `fatal_o` is set and the image ends at byte 15. `done_o` pulses without waiting for more bytes.
- R4: A CRC-32C is run over bytes 13..size-1. It is reflected, uses polynomial 0x82F63B78, starts at all ones and inverts its final value. If the result differs from the little-endian word in bytes 9..12, `crc32_warn_o` is set. This mismatch alone never sets `fatal_o`.
- R5: `vendor_o` equals bytes 16..17 little-endian. `model_o` equals bytes 18..19 little-endian.
- R6: `rev_warn_o` is set exactly when byte 13 is greater than 2.
- R7: If `in_last_i` comes with a byte before the total size is reached, that byte ends the image. `fatal_o` is set, `crc32_warn_o` is clear, and the fields received so far are reported. If `in_last_i` comes with the final byte, the image is treated as complete.
- R8: `done_o` is high for exactly one cycle, in the cycle after the byte that ends the image. All result outputs change only with that pulse. The next valid byte is byte 0 of a new image.
- R9: After reset, `done_o` and every result output are zero.
- R10: In a cycle where `in_valid_i` is low, `in_byte_i` and `in_last_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| in_valid_i | input | 1 | a byte is presented this cycle |
| in_byte_i | input | 8 | stream byte |
| in_last_i | input | 1 | this byte is the last the source will send |
| done_o | output | 1 | one-cycle pulse: the results for an image are ready |
| ident_o | output | 64 | 64-bit identifier |
| vendor_o | output | 16 | vendor code |
| model_o | output | 16 | model code |
| image_size_o | output | LEN_BITS+1 | total image size in bytes (0 if the length word was not received) |
| fatal_o | output | 1 | bad identifier check, image too small, or truncated stream |
| crc32_warn_o | output | 1 | the data checksum does not match |
| rev_warn_o | output | 1 | the revision is greater than 2 |

## Verification
The bench targets the following corner cases:

- **Length masking.** Byte 15 carries junk in its upper six bits. A design that failed to mask would report an enormous size and wait forever.
- **Short images.** The bench sends an image whose size is below 22 and checks that the block finishes right after byte 15. A design that missed this would swallow the next image's bytes as data.
- **Truncation.** The end flag is sent both early and exactly on the final byte. A late end check would turn a clean image into a fatal one, or would miss a truncated image.
- **Idle cycles.** Idle cycles carry junk bytes and a raised end flag. A design that sampled these without checking valid would corrupt the fields or end the image early.
- **Warning kept separate.** Images with only a data-checksum error must stay non-fatal.
- **Full length.** The longest possible data length exercises the size counter to its full width.

// File: rtl/idrom_pkg.sv
package idrom_pkg;

  // fixed header layout (positions are decoded by neighbours, so they are kept)
  localparam int unsigned ID_FIRST    = 1;
  localparam int unsigned ID_BYTES    = 8;
  localparam int unsigned REF32_FIRST = 9;
  localparam int unsigned REV_POS     = 13;
  localparam int unsigned LEN_LO_POS  = 14;
  localparam int unsigned LEN_HI_POS  = 15;
  localparam int unsigned VEND_POS    = 16;
  localparam int unsigned MODEL_POS   = 18;
  localparam int unsigned DATA_START  = 13;
  localparam int unsigned HDR_BYTES   = 22;
  localparam int unsigned CAP_BYTES   = MODEL_POS + 2;

  localparam logic [7:0]  CRC8_POLY   = 8'h07;
  localparam logic [7:0]  CRC8_SEED   = 8'hFF;
  localparam logic [31:0] CRC32_POLY  = 32'h82F63B78;
  localparam logic [31:0] CRC32_SEED  = 32'hFFFF_FFFF;

  // one byte of the identifier check: xor in, then eight MSB-first shifts
  function automatic logic [7:0] crc8_upd(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] v;
    v = c ^ b;
    for (int j = 0; j < 8; j++) begin
      v = {v[6:0], 1'b0} ^ (v[7] ? CRC8_POLY : 8'h00);
    end
    return v;
  endfunction

  // one byte of the reflected data checksum
  function automatic logic [31:0] crc32c_upd(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] v;
    v = c ^ {24'h0, b};
    for (int j = 0; j < 8; j++) begin
      v = (v >> 1) ^ (v[0] ? CRC32_POLY : 32'h0);
    end
    return v;
  endfunction

  // total image size from the masked data length
  function automatic logic [15:0] total_size(input logic [15:0] len);
    return len + 16'(DATA_START);
  endfunction

endpackage

// File: rtl/idrom_crc_acc.sv
module idrom_crc_acc
  import idrom_pkg::*;
#(
  parameter int           W    = 8,
  parameter bit           REFL = 1'b0,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_i,
  input  logic         step_i,
  input  logic [7:0]   data_i,
  output logic [W-1:0] crc_nx_o
);

  logic [W-1:0] crc_q;

  generate
    if (REFL) begin : g_refl
      assign crc_nx_o = W'(crc32c_upd(32'(crc_q), data_i));
    end else begin : g_msb
      assign crc_nx_o = W'(crc8_upd(8'(crc_q), data_i));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '0;
    else if (init_i) crc_q <= SEED;
    else if (step_i) crc_q <= crc_nx_o;
  end

endmodule

// File: rtl/idrom_field_cap.sv
module idrom_field_cap
  import idrom_pkg::*;
#(
  parameter int PW       = 11,
  parameter int LEN_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take_i,
  input  logic [PW-1:0]       pos_i,
  input  logic [7:0]          data_i,
  output logic [7:0]          ref8_o,
  output logic [63:0]         id_o,
  output logic [31:0]         ref32_o,
  output logic [7:0]          rev_o,
  output logic [LEN_BITS-1:0] len_o,
  output logic [15:0]         vendor_o,
  output logic [15:0]         model_o
);

  logic [7:0] hdr_q [CAP_BYTES];
  logic [7:0] hdr_d [CAP_BYTES];

  // the current byte is merged in so that fields are usable in its own cycle
  always_comb begin
    for (int i = 0; i < CAP_BYTES; i++) begin
      hdr_d[i] = hdr_q[i];
      if (take_i && pos_i == '0)        hdr_d[i] = 8'h00;
      if (take_i && pos_i == PW'(i))    hdr_d[i] = data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CAP_BYTES; i++) hdr_q[i] <= 8'h00;
    end else if (take_i) begin
      hdr_q <= hdr_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < ID_BYTES; g++) begin : g_id
      assign id_o[8*g +: 8] = hdr_d[ID_FIRST + g];
    end
    for (g = 0; g < 4; g++) begin : g_ref32
      assign ref32_o[8*g +: 8] = hdr_d[REF32_FIRST + g];
    end
  endgenerate

  assign ref8_o   = hdr_d[0];
  assign rev_o    = hdr_d[REV_POS];
  assign len_o    = LEN_BITS'({hdr_d[LEN_HI_POS], hdr_d[LEN_LO_POS]});
  assign vendor_o = {hdr_d[VEND_POS + 1], hdr_d[VEND_POS]};
  assign model_o  = {hdr_d[MODEL_POS + 1], hdr_d[MODEL_POS]};

endmodule

// File: rtl/idrom_hdr_check.sv
module idrom_hdr_check
  import idrom_pkg::*;
#(
  parameter int LEN_BITS = 10,
  parameter int MAX_REV  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic [7:0]        in_byte_i,
  input  logic              in_last_i,
  output logic              done_o,
  output logic [63:0]       ident_o,
  output logic [15:0]       vendor_o,
  output logic [15:0]       model_o,
  output logic [LEN_BITS:0] image_size_o,
  output logic              fatal_o,
  output logic              crc32_warn_o,
  output logic              rev_warn_o
);

  localparam int PW = LEN_BITS + 1;
  localparam logic [PW-1:0] P_ZERO    = '0;
  localparam logic [PW-1:0] P_ID_LO   = PW'(ID_FIRST);
  localparam logic [PW-1:0] P_ID_HI   = PW'(ID_FIRST + ID_BYTES - 1);
  localparam logic [PW-1:0] P_LEN_HI  = PW'(LEN_HI_POS);
  localparam logic [PW-1:0] P_DATA    = PW'(DATA_START);
  localparam logic [PW-1:0] P_HDR     = PW'(HDR_BYTES);

  // named internal events, also observed by the checker
  logic          take;
  logic [PW-1:0] pos_q;
  logic [PW-1:0] size_q;
  logic [PW-1:0] size_now;
  logic [PW-1:0] cur_size;
  logic          at_len_hi;
  logic          size_known;
  logic          short_evt;
  logic          last_evt;
  logic          trunc_evt;
  logic          end_evt;
  logic          crc8_bad;
  logic          crc32_bad;
  logic          id_bad_q;
  logic          id_bad_nx;

  logic [7:0]          ref8_d;
  logic [63:0]         id_d;
  logic [31:0]         ref32_d;
  logic [7:0]          rev_d;
  logic [LEN_BITS-1:0] len_d;
  logic [15:0]         vendor_d;
  logic [15:0]         model_d;
  logic [7:0]          crc8_nx;
  logic [31:0]         crc32_nx;

  idrom_field_cap #(.PW(PW), .LEN_BITS(LEN_BITS)) u_fields (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_i   (take),
    .pos_i    (pos_q),
    .data_i   (in_byte_i),
    .ref8_o   (ref8_d),
    .id_o     (id_d),
    .ref32_o  (ref32_d),
    .rev_o    (rev_d),
    .len_o    (len_d),
    .vendor_o (vendor_d),
    .model_o  (model_d)
  );

  idrom_crc_acc #(.W(8), .REFL(1'b0), .SEED(CRC8_SEED)) u_crc8 (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_i   (take && pos_q == P_ZERO),
    .step_i   (take && pos_q >= P_ID_LO && pos_q <= P_ID_HI),
    .data_i   (in_byte_i),
    .crc_nx_o (crc8_nx)
  );

  idrom_crc_acc #(.W(32), .REFL(1'b1), .SEED(CRC32_SEED)) u_crc32 (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_i   (take && pos_q == P_ZERO),
    .step_i   (take && pos_q >= P_DATA),
    .data_i   (in_byte_i),
    .crc_nx_o (crc32_nx)
  );

  assign take       = in_valid_i;
  assign at_len_hi  = (pos_q == P_LEN_HI);
  assign size_known = (pos_q > P_LEN_HI);
  assign size_now   = at_len_hi ? PW'(total_size(16'(len_d))) : size_q;
  assign cur_size   = (at_len_hi || size_known) ? size_now : '0;

  assign short_evt  = take && at_len_hi && (size_now < P_HDR);
  assign last_evt   = take && (at_len_hi || size_known) && (size_now >= P_HDR)
                      && (pos_q == size_now - PW'(1));
  assign trunc_evt  = take && in_last_i && !last_evt && !short_evt;
  assign end_evt    = last_evt || short_evt || trunc_evt;

  assign crc8_bad   = take && (pos_q == P_ID_HI) && (crc8_nx != ref8_d);
  assign id_bad_nx  = ((pos_q == P_ZERO) ? 1'b0 : id_bad_q) || crc8_bad;
  assign crc32_bad  = last_evt && ((~crc32_nx) != ref32_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      size_q   <= '0;
      id_bad_q <= 1'b0;
    end else if (take) begin
      pos_q    <= end_evt ? '0 : pos_q + PW'(1);
      id_bad_q <= id_bad_nx;
      if (at_len_hi) size_q <= size_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o       <= 1'b0;
      ident_o      <= '0;
      vendor_o     <= '0;
      model_o      <= '0;
      image_size_o <= '0;
      fatal_o      <= 1'b0;
      crc32_warn_o <= 1'b0;
      rev_warn_o   <= 1'b0;
    end else begin
      done_o <= end_evt;
      if (end_evt) begin
        ident_o      <= id_d;
        vendor_o     <= vendor_d;
        model_o      <= model_d;
        image_size_o <= cur_size;
        fatal_o      <= id_bad_nx || short_evt || trunc_evt;
        crc32_warn_o <= crc32_bad;
        rev_warn_o   <= (rev_d > 8'(MAX_REV));
      end
    end
  end

endmodule

// File: rtl/idrom_hdr_check_sva.sv
module idrom_hdr_check_sva #(
  parameter int PW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid_i,
  input logic          done_o,
  input logic          fatal_o,
  input logic          crc32_warn_o,
  input logic [63:0]   ident_o,
  input logic [PW-1:0] image_size_o,
  input logic          end_evt,
  input logic [PW-1:0] pos_q
);

  localparam logic [PW-1:0] HDR_MIN = PW'(22);

  p_end_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> done_o);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(ident_o) && $stable(fatal_o) && $stable(image_size_o)));

  p_short_fatal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && image_size_o < HDR_MIN) |-> fatal_o);

  p_warn_complete_r4: assert property (@(posedge clk) disable iff (!rst_n)
    crc32_warn_o |-> (image_size_o >= HDR_MIN));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> $stable(pos_q));

endmodule

bind idrom_hdr_check idrom_hdr_check_sva #(.PW(PW)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid_i   (in_valid_i),
  .done_o       (done_o),
  .fatal_o      (fatal_o),
  .crc32_warn_o (crc32_warn_o),
  .ident_o      (ident_o),
  .image_size_o (image_size_o),
  .end_evt      (end_evt),
  .pos_q        (pos_q)
);

// File: tb/test_idrom_hdr_check.sv
`timescale 1ns/1ps
module test_idrom_hdr_check;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_last = 1'b0;
  logic        done;
  logic [63:0] ident;
  logic [15:0] vendor, model;
  logic [10:0] isize;
  logic        fatal, cwarn, rwarn;

  always #2 clk = ~clk;

  idrom_hdr_check i_idrom_hdr_check (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_byte_i(in_byte),
    .in_last_i(in_last), .done_o(done), .ident_o(ident), .vendor_o(vendor),
    .model_o(model), .image_size_o(isize), .fatal_o(fatal),
    .crc32_warn_o(cwarn), .rev_warn_o(rwarn)
  );

  typedef struct packed {
    logic [9:0]  len;
    logic [7:0]  rev;
    logic [63:0] id;
    logic [15:0] vend;
    logic [15:0] model;
    logic        bad8;
    logic        bad32;
    logic        gap;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{10'd9,    8'd0, 64'h0123_4567_89AB_CDEF, 16'h8086, 16'h1513, 1'b0, 1'b0, 1'b0},
    '{10'd40,   8'd1, 64'hFEDC_BA98_7654_3210, 16'h1D6B, 16'h0002, 1'b0, 1'b0, 1'b1},
    '{10'd20,   8'd3, 64'h0000_0000_0000_0001, 16'hABCD, 16'h1234, 1'b0, 1'b1, 1'b0},
    '{10'd15,   8'd2, 64'hDEAD_BEEF_CAFE_F00D, 16'h0001, 16'hFFFF, 1'b1, 1'b0, 1'b0},
    '{10'd1023, 8'd7, 64'h5A5A_A5A5_0F0F_F0F0, 16'h4242, 16'h2424, 1'b0, 1'b0, 1'b0},
    '{10'd64,   8'd0, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1}
  };

  logic [7:0] img [0:1099];
  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // build an image in img[] from a vector, checksums computed bit by bit
  task automatic build(input vec_t v);
    int size;
    logic [7:0]  c8;
    logic [31:0] c32;
    logic        fb;
    size = int'(v.len) + 13;
    for (int k = 0; k < 8; k++) img[1+k] = v.id[8*k +: 8];
    img[13] = v.rev;
    img[14] = v.len[7:0];
    img[15] = {6'b110101, v.len[9:8]};
    img[16] = v.vend[7:0];  img[17] = v.vend[15:8];
    img[18] = v.model[7:0]; img[19] = v.model[15:8];
    for (int k = 20; k < size; k++) img[k] = 8'((k * 13) + int'(v.rev) + 1);
    c8 = 8'hFF;
    for (int k = 1; k <= 8; k++)
      for (int i = 0; i < 8; i++) begin
        fb = c8[7] ^ img[k][7-i];
        c8 = {c8[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
    img[0] = v.bad8 ? (c8 ^ 8'h5A) : c8;
    c32 = 32'hFFFF_FFFF;
    for (int k = 13; k < size; k++)
      for (int i = 0; i < 8; i++) begin
        fb = c32[0] ^ img[k][i];
        c32 = (c32 >> 1) ^ (fb ? 32'h82F63B78 : 32'h0);
      end
    c32 = ~c32;
    for (int k = 0; k < 4; k++) img[9+k] = c32[8*k +: 8];
    if (v.bad32) img[10] = img[10] ^ 8'h01;
  endtask

  // drive count bytes; idle cycles carry junk that must be ignored
  task automatic send(input int count, input bit gap, input bit last_flag);
    for (int k = 0; k < count; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = img[k];
      in_last  = last_flag && (k == count - 1);
      if (gap && k != count - 1) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'hA5;
        in_last  = 1'b1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_byte  = 8'h00;
  endtask

  initial begin
    vec_t v;
    logic [63:0] held_id;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "done", 64'(done), 64'd0);
    chk("R9", "ident", ident, 64'd0);
    chk("R9", "fatal", 64'(fatal), 64'd0);
    chk("R9", "size", 64'(isize), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int n = 0; n < NV; n++) begin
      v = VECS[n];
      build(v);
      send(int'(v.len) + 13, v.gap, 1'b0);
      chk("R8", "done", 64'(done), 64'd1);
      chk("R1", "ident", ident, v.id);
      chk("R1", "fatal", 64'(fatal), 64'(v.bad8));
      chk("R2", "size", 64'(isize), 64'(int'(v.len) + 13));
      chk("R4", "crc32 warn", 64'(cwarn), 64'(v.bad32));
      chk("R5", "vendor", 64'(vendor), 64'(v.vend));
      chk("R5", "model", 64'(model), 64'(v.model));
      chk("R6", "rev warn", 64'(rwarn), 64'(v.rev > 8'd2));
      if (v.gap) chk("R10", "ident with idle junk", ident, v.id);
      @(negedge clk);
      chk("R8", "done single cycle", 64'(done), 64'd0);
    end

    // R3: short image ends after byte 15
    v = '{10'd5, 8'd0, 64'h1111_2222_3333_4444, 16'h0A0B, 16'h0C0D, 1'b0, 1'b0, 1'b0};
    build(v);
    send(16, 1'b0, 1'b0);
    chk("R3", "done after byte 15", 64'(done), 64'd1);
    chk("R3", "fatal short", 64'(fatal), 64'd1);
    chk("R3", "size", 64'(isize), 64'd18);

    // R8: next byte starts a fresh image
    v = '{10'd12, 8'd1, 64'h7766_5544_3322_1100, 16'h0102, 16'h0304, 1'b0, 1'b0, 1'b0};
    build(v);
    send(25, 1'b0, 1'b1);
    chk("R8", "fresh image ident", ident, 64'h7766_5544_3322_1100);
    chk("R7", "end flag on final byte is clean", 64'(fatal), 64'd0);
    chk("R7", "no warn", 64'(cwarn), 64'd0);

    // R7: early end flag
    v = '{10'd30, 8'd0, 64'h0BAD_F00D_0BAD_F00D, 16'h5555, 16'h6666, 1'b0, 1'b0, 1'b0};
    build(v);
    send(20, 1'b0, 1'b1);
    chk("R7", "done on early end", 64'(done), 64'd1);
    chk("R7", "fatal truncated", 64'(fatal), 64'd1);
    chk("R7", "crc32 warn clear", 64'(cwarn), 64'd0);
    chk("R7", "model captured", 64'(model), 64'h6666);
    chk("R7", "size known", 64'(isize), 64'd43);
    held_id = ident;

    // R8: results held while idle
    repeat (5) @(negedge clk);
    chk("R8", "done idle", 64'(done), 64'd0);
    chk("R8", "ident held", ident, held_id);
    chk("R8", "fatal held", 64'(fatal), 64'd1);

    // R7: truncation before the length is known
    build(v);
    send(6, 1'b0, 1'b1);
    chk("R7", "fatal very early", 64'(fatal), 64'd1);
    chk("R7", "size unknown", 64'(isize), 64'd0);

    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      report();
      $finish;
    end
  end

endmodule